// File: doc/BRIEF.md
# I2C Addressed Memory Target

This block is a bus target for a two-wire serial bus that looks to a controller like a small serial byte memory. It runs on a fast system clock, brings the clock line and the data line in through synchronizer flops, and detects START, STOP and the clock edges from those synchronized samples. It answers only to one fixed 7-bit device address.

After the device address with the write direction, the controller sends the memory pointer. This is either a high byte followed by a low byte, or one byte when the short-pointer mode is chosen. Any further bytes in the same transaction are stored at the pointer, and the pointer advances after each one. To read at a chosen location, the controller sets the pointer with a write header and then issues a repeated START with the read direction. The block then shifts out the stored bytes, most significant bit first, until the controller answers a byte with not-acknowledge.

The block never drives the data line high. It only asserts an output enable that pulls the line low, and the pad or wired-AND logic outside the block does the rest. The storage is a register array of 2^MEM_AW bytes.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset every memory byte reads 0x00 and `sda_oe` is 0.
- R2: A first byte after START whose upper 7 bits equal `DEV_ADDR` (default 7'b1010000) is acknowledged by pulling SDA low during the ninth clock. Any other value gets no acknowledge, and all bytes up to the next START are ignored, so memory is unchanged.
- R3: With `TWO_BYTE_PTR`=1, the write header is followed by a high pointer byte (its low 5 bits form pointer bits 12:8) and then a low pointer byte (bits 7:0). Each byte is acknowledged. Memory is indexed by the low `MEM_AW` pointer bits.
- R4: Each data byte after the pointer is acknowledged and stored at the pointer, and the pointer then advances. The low `MEM_AW` bits wrap from all-ones to zero and the upper bits are kept.
- R5: After a repeated START with direction bit 1 (read), the block keeps the pointer set by the previous header and shifts out the byte stored there, most significant bit first.
- R6: When the controller acknowledges (SDA low) a read byte, the next byte comes from the advanced pointer. On a not-acknowledge (SDA high), SDA is released and stays released until the next START.
- R7: A STOP or START received partway through a byte aborts that byte. After a STOP the block waits for a START; after a START it decodes a fresh device address.
- R8: With `TWO_BYTE_PTR`=0, a single pointer byte follows the write header, and write and read then behave as in R4 to R6.
- R9: SDA is only ever pulled low and never driven high. A new pull-low begins only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench puts two instances on one wired-AND bus. The first uses the default address 7'b1010000 with the two-byte pointer and `MEM_AW`=8. The second uses address 7'b1010001 with the one-byte pointer and `MEM_AW`=6. The 256-byte depth of the first instance makes the pointer wrap from 0xFF to 0x00 reachable in a two-byte write and a two-byte sequential read. The high-pointer byte 0x1F shows that upper pointer bits do not change which byte is indexed. The second instance covers the short-pointer mode and shows that each target ignores traffic meant for the other.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_DEV,    // receiving device address + direction
        ST_PHI,    // receiving high pointer byte
        ST_PLO,    // receiving low pointer byte
        ST_WR,     // receiving data bytes
        ST_RD      // transmitting data bytes
    } tgt_state_e;

    // bit counter landmarks inside one byte frame
    localparam logic [3:0] CNT_BYTE   = 4'd8;   // eight bits shifted
    localparam logic [3:0] CNT_ACK    = 4'd9;   // inside acknowledge slot
    localparam logic [3:0] CNT_RELOAD = 4'd10;  // controller acked a read byte

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] raw;
    logic [1:0] synced;
    logic [1:0] prev_q;

    assign raw = {scl_i, sda_i};

    // one synchronizer chain per bus line
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b11;
        else        prev_q <= synced;
    end

    assign scl_s     = synced[1];
    assign sda_s     = synced[0];
    assign scl_rise  = scl_s & ~prev_q[1];
    assign scl_fall  = ~scl_s & prev_q[1];
    assign start_det = scl_s & prev_q[1] & prev_q[0] & ~sda_s;
    assign stop_det  = scl_s & prev_q[1] & ~prev_q[0] & sda_s;

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= '0;
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR     = 7'b1010000,
    parameter bit         TWO_BYTE_PTR = 1'b1,
    parameter int         MEM_AW       = 8,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int HI_W  = 5;
    localparam int PTR_W = 8 + HI_W;
    localparam logic [PTR_W-1:0] WRAP_MASK = PTR_W'((1 << MEM_AW) - 1);

    typedef struct packed {
        tgt_state_e       st;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic             oe;
        logic [PTR_W-1:0] ptr;
    } tgt_regs_t;

    tgt_regs_t r_d, r_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic mem_we;
    logic [7:0] mem_rdata;
    logic [PTR_W-1:0] ptr_next;
    tgt_state_e st_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_mem_array #(.AW(MEM_AW), .DW(8)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (r_q.ptr[MEM_AW-1:0]),
        .wdata (r_q.sh),
        .raddr (r_q.ptr[MEM_AW-1:0]),
        .rdata (mem_rdata)
    );

    // advance within the memory depth, keep the bits above it
    assign ptr_next = (r_q.ptr & ~WRAP_MASK) | ((r_q.ptr + PTR_W'(1)) & WRAP_MASK);

    always_comb begin
        r_d    = r_q;
        mem_we = 1'b0;
        if (stop_det) begin
            r_d.st  = ST_IDLE;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else if (start_det) begin
            r_d.st  = ST_DEV;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else begin
            case (r_q.st)
                ST_IDLE: ;
                ST_RD: begin
                    if (scl_rise) begin
                        if (r_q.cnt < CNT_BYTE) begin
                            r_d.cnt = r_q.cnt + 4'd1;
                        end else if (r_q.cnt == CNT_ACK) begin
                            if (sda_s) r_d.st  = ST_IDLE;    // controller NACK
                            else       r_d.cnt = CNT_RELOAD;
                        end
                    end else if (scl_fall) begin
                        if (r_q.cnt != 4'd0 && r_q.cnt < CNT_BYTE) begin
                            r_d.sh = {r_q.sh[6:0], 1'b0};
                            r_d.oe = ~r_q.sh[6];
                        end else if (r_q.cnt == CNT_BYTE) begin
                            r_d.oe  = 1'b0;
                            r_d.cnt = CNT_ACK;
                            r_d.ptr = ptr_next;
                        end else if (r_q.cnt == CNT_RELOAD) begin
                            r_d.sh  = mem_rdata;
                            r_d.oe  = ~mem_rdata[7];
                            r_d.cnt = '0;
                        end
                    end
                end
                default: begin
                    if (scl_rise && r_q.cnt < CNT_BYTE) begin
                        r_d.sh  = {r_q.sh[6:0], sda_s};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == CNT_BYTE) begin
                        r_d.oe  = 1'b1;
                        r_d.cnt = CNT_ACK;
                        case (r_q.st)
                            ST_DEV: begin
                                if (r_q.sh[7:1] != DEV_ADDR) begin
                                    r_d.oe  = 1'b0;
                                    r_d.st  = ST_IDLE;
                                    r_d.cnt = '0;
                                end
                            end
                            ST_PHI: r_d.ptr[PTR_W-1:8] = r_q.sh[HI_W-1:0];
                            ST_PLO: r_d.ptr[7:0] = r_q.sh;
                            ST_WR: begin
                                mem_we  = 1'b1;
                                r_d.ptr = ptr_next;
                            end
                            default: ;
                        endcase
                    end else if (scl_fall && r_q.cnt == CNT_ACK) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        case (r_q.st)
                            ST_DEV: begin
                                if (r_q.sh[0]) begin
                                    r_d.st = ST_RD;
                                    r_d.sh = mem_rdata;
                                    r_d.oe = ~mem_rdata[7];
                                end else begin
                                    r_d.st = TWO_BYTE_PTR ? ST_PHI : ST_PLO;
                                end
                            end
                            ST_PHI:  r_d.st = ST_PLO;
                            default: r_d.st = ST_WR;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.cnt <= '0;
            r_q.sh  <= '0;
            r_q.oe  <= 1'b0;
            r_q.ptr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe = r_q.oe;
    assign st_q   = r_q.st;

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
    import i2c_mem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input tgt_state_e st,
    input logic       oe,
    input logic       we
);

    // R9: a new pull-low only begins while the bus clock is low
    a_r9_pull_low_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> !scl_s);

    // R6: no drive while waiting for a START
    a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !oe);

    // R7: START restarts address decoding and releases the line
    a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (st == ST_DEV && !oe));

    // R7: STOP returns to idle
    a_r7_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE));

    // R4: storage is written only while receiving data bytes
    a_r4_write_in_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (st == ST_WR));

endmodule

bind i2c_mem_target i2c_mem_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .st        (st_q),
    .oe        (sda_oe),
    .we        (mem_we)
);

// File: tb/i2c_mem_target_tb_top.sv
module i2c_mem_target_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;              // system clocks per quarter bus bit
    localparam int WATCHDOG = 200000;

    // {pointer, data} pairs for the table walk
    localparam logic [23:0] VEC [4] = '{
        {16'h0005, 8'hA5},
        {16'h1F80, 8'h3C},
        {16'h0012, 8'h5A},
        {16'h00FE, 8'hC3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic oe_a, oe_b;
    wire  sda_bus = sda_m & ~oe_a & ~oe_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_mem_target #(.DEV_ADDR(7'b1010000), .TWO_BYTE_PTR(1'b1), .MEM_AW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(oe_a));

    i2c_mem_target #(.DEV_ADDR(7'b1010001), .TWO_BYTE_PTR(1'b0), .MEM_AW(6)) dut_b (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(oe_b));

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sda_m = b[7-i]; tick(Q);
            scl_m = 1'b1;   tick(2*Q);
            scl_m = 1'b0;   tick(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = sda_bus; tick(Q);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[7-i] = sda_bus; tick(Q);
            scl_m = 1'b0; tick(2);
        end
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    // header: START, device+write, pointer byte(s); acks OR-ed into nak
    task automatic header(input logic [6:0] dev, input bit two, input logic [15:0] a,
                          output logic nak);
        logic k;
        bus_start;
        send_byte({dev, 1'b0}, k); nak = k;
        if (two) begin send_byte(a[15:8], k); nak |= k; end
        send_byte(a[7:0], k); nak |= k;
    endtask

    task automatic mem_write(input logic [6:0] dev, input bit two, input logic [15:0] a,
                             input logic [7:0] d0, input logic [7:0] d1, input int n,
                             output logic nak);
        logic k;
        header(dev, two, a, nak);
        send_byte(d0, k); nak |= k;
        if (n > 1) begin send_byte(d1, k); nak |= k; end
        bus_stop;
    endtask

    task automatic mem_read(input logic [6:0] dev, input bit two, input logic [15:0] a,
                            input int n, output logic [7:0] r0, output logic [7:0] r1,
                            output logic nak, output logic released);
        logic k;
        header(dev, two, a, nak);
        bus_start;                        // repeated START
        send_byte({dev, 1'b1}, k); nak |= k;
        r1 = 8'h00;
        if (n > 1) begin
            recv_byte(1'b0, r0);
            recv_byte(1'b1, r1);
        end else begin
            recv_byte(1'b1, r0);
        end
        tick(Q);
        released = !oe_a && !oe_b && sda_bus;
        bus_stop;
    endtask

    initial begin
        logic nak, rel;
        logic [7:0] r0, r1;

        tick(3);
        rst_n = 1'b1;
        tick(4);

        // R1: reset state
        check(!oe_a && !oe_b, "R1 sda released after reset", {oe_a, oe_b}, 0);
        mem_read(7'b1010000, 1'b1, 16'h0040, 1, r0, r1, nak, rel);
        check(r0 == 8'h00, "R1 memory cleared", r0, 8'h00);

        // table walk: write then random read back (R3, R4, R5, R2 acks)
        foreach (VEC[i]) begin
            mem_write(7'b1010000, 1'b1, VEC[i][23:8], VEC[i][7:0], 8'h00, 1, nak);
            check(!nak, "R2/R3 write header and data acknowledged", nak, 0);
            mem_read(7'b1010000, 1'b1, VEC[i][23:8], 1, r0, r1, nak, rel);
            check(!nak, "R5 read header acknowledged", nak, 0);
            check(r0 == VEC[i][7:0], "R5 random read data", r0, VEC[i][7:0]);
        end

        // R3: high pointer bits do not alter the indexed byte (0x1F80 aliases 0x0080)
        mem_read(7'b1010000, 1'b1, 16'h0080, 1, r0, r1, nak, rel);
        check(r0 == 8'h3C, "R3 index uses low pointer bits", r0, 8'h3C);

        // R2: wrong device address -> no ack, memory untouched
        mem_write(7'b1010010, 1'b1, 16'h0005, 8'h99, 8'h00, 1, nak);
        check(nak, "R2 mismatch not acknowledged", nak, 1);
        mem_read(7'b1010000, 1'b1, 16'h0005, 1, r0, r1, nak, rel);
        check(r0 == 8'hA5, "R2 mismatch left memory unchanged", r0, 8'hA5);

        // R4: two bytes across the wrap point 0xFF -> 0x00
        mem_write(7'b1010000, 1'b1, 16'h00FF, 8'h11, 8'h22, 2, nak);
        check(!nak, "R4 burst write acknowledged", nak, 0);
        mem_read(7'b1010000, 1'b1, 16'h0000, 1, r0, r1, nak, rel);
        check(r0 == 8'h22, "R4 pointer wrapped to zero", r0, 8'h22);

        // R6: sequential read with ACK then NACK, across the wrap
        mem_read(7'b1010000, 1'b1, 16'h00FF, 2, r0, r1, nak, rel);
        check(r0 == 8'h11, "R6 first sequential byte", r0, 8'h11);
        check(r1 == 8'h22, "R6 second sequential byte after ack", r1, 8'h22);
        check(rel, "R6 sda released after nack", rel, 1);

        // R7: STOP in the middle of a byte aborts it
        bus_start;
        send_byte({7'b1010000, 1'b0}, nak);
        send_bits(8'h00, 4);
        bus_stop;
        check(!oe_a && !oe_b, "R7 released after aborting stop", {oe_a, oe_b}, 0);
        mem_write(7'b1010000, 1'b1, 16'h0030, 8'h77, 8'h00, 1, nak);
        check(!nak, "R7 transaction after stop abort acknowledged", nak, 0);

        // R7: START in the middle of a byte aborts it
        bus_start;
        send_byte({7'b1010000, 1'b0}, nak);
        send_bits(8'hFF, 5);
        mem_read(7'b1010000, 1'b1, 16'h0030, 1, r0, r1, nak, rel);
        check(!nak, "R7 start abort then new address acknowledged", nak, 0);
        check(r0 == 8'h77, "R7 data intact after start abort", r0, 8'h77);

        // R8: one-byte pointer instance
        mem_write(7'b1010001, 1'b0, 16'h0010, 8'h6E, 8'h00, 1, nak);
        check(!nak, "R8 short-pointer write acknowledged", nak, 0);
        mem_read(7'b1010001, 1'b0, 16'h0010, 1, r0, r1, nak, rel);
        check(r0 == 8'h6E, "R8 short-pointer read back", r0, 8'h6E);
        mem_read(7'b1010000, 1'b1, 16'h0010, 1, r0, r1, nak, rel);
        check(r0 == 8'h00, "R8 other target unaffected", r0, 8'h00);

        // R9: idle bus with SCL high, no pull-low
        tick(Q);
        check(!oe_a && !oe_b && scl_m, "R9 no drive on idle bus", {oe_a, oe_b}, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule